// File: doc/BRIEF.md
# Idle-Time Drive Polling and Power-Down Scheduler

This block runs the background housekeeping loop of a floppy disk controller while the controller waits for a command. A fixed interval is measured in rate ticks. The tick is a one-cycle enable whose period follows the selected data rate. When the interval expires the block runs one pass of a loop. The pass visits the logical drives one after another. During each visit it records a ready-changed event, issues any step pulse that is still pending, and tracks the automatic low-power countdown.

After a hardware reset or a software reset, every drive is treated as if its ready line had toggled. The first pass therefore flags all drives and raises the interrupt. The host then clears the flags with one sense-interrupt request per drive. The flags come back in ascending order, starting with drive 0. Setting the polling-disable configuration bit before the first pass suppresses this start-up status. Stepping and power-down keep running inside the loop even when polling is disabled. While a pass is in progress the busy output stays high. The command sequencer uses it to hold back the ready indication for the next command byte.

Top module: `fdc_idle_sched`

## Requirements
- R1: Reset state. While reset is applied, and after either reset, `irq`, `poll_busy`, `sense_vld`, `step_o` and `pwr_down` are 0.
- R2: Loop start and length. While `idle` is 1 and no pass is running, counting starts. On the POLL_TICKS-th `tick`, the pass starts and `poll_busy` rises on the next clock edge. The pass then lasts NUM_DRV*SLOT_CYC cycles. Whenever `idle` is 0, the interval count restarts from zero.
- R3: In the first pass after a reset, if `poll_dis` is 0, each drive's ready-changed flag is set when the pass visits that drive, and `irq` goes high. Later passes set no flag until the next reset.
- R4: If `poll_dis` is 1 when the pass visits a drive, the reset-time event for that drive is discarded. That drive's flag is not set, and no later pass sets it.
- R5: A one-cycle `sense_req` produces `sense_vld`=1 on the next cycle. In that response, `sense_drv` is the lowest-numbered flagged drive, `sense_hit` is 1, and that flag is cleared. With no flags set, the response has `sense_hit`=0 and `sense_drv`=0. `irq` is 1 exactly while any flag remains.
- R6: A `step_req` marks a step as pending for `step_req_drv`, with direction `step_req_dir`. One cycle after the pass visits that drive, `step_o` pulses for one cycle. In that cycle `step_drv` names the drive and `step_dir` carries the requested direction. This happens whatever the value of `poll_dis`.
- R7: The countdown runs while `motor_off_exp` and `auto_pd_en` are both 1. After PD_TICKS ticks, `pwr_down` rises one cycle after the next pass visits drive 0, and it then stays high. With `auto_pd_en` at 0, `pwr_down` never rises.
- R8: A cycle with `cmd_act` or `motor_on` high clears `pwr_down` on the next cycle and restarts the countdown.
- R9: Once started, a pass runs to completion and `poll_busy` stays high throughout. This holds even if `idle` falls or `cmd_act` arrives during the pass.
- R10: A `soft_rst` pulse returns the block to its reset state and re-arms the start-up ready toggle for every drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_rst | input | 1 | Software reset pulse |
| tick | input | 1 | One-cycle time-base enable, scaled to the data rate |
| idle | input | 1 | Controller is in its idle phase |
| poll_dis | input | 1 | Ready-change polling disabled |
| sense_req | input | 1 | Sense-interrupt request pulse |
| step_req | input | 1 | Queue a step for one drive |
| step_req_drv | input | DRV_W | Drive addressed by `step_req` |
| step_req_dir | input | 1 | Step direction level to use |
| cmd_act | input | 1 | Command activity seen |
| motor_on | input | 1 | Motor-on request |
| motor_off_exp | input | 1 | Motor-off time has expired |
| auto_pd_en | input | 1 | Automatic power-down enabled |
| irq | output | 1 | Ready-changed interrupt |
| poll_busy | output | 1 | Pass in progress; hold off command byte ready |
| sense_vld | output | 1 | Sense response valid |
| sense_hit | output | 1 | Sense response carried a flagged drive |
| sense_drv | output | DRV_W | Drive number returned by sense |
| step_o | output | 1 | Step pulse |
| step_dir | output | 1 | Direction level for the step |
| step_drv | output | DRV_W | Drive receiving the step |
| pwr_down | output | 1 | Low-power state requested |

## Verification
The first stimulus is a plain reset followed by idle time. It shows whether all four flags are latched and whether they drain in ascending order with a final empty response. The same sequence is repeated with polling disabled, and then again after a software reset. Together these separate a discarded toggle from a re-armed one. Step requests are queued with polling off, for two drives and with opposite directions. This exposes the slot a pulse lands in and the direction level it carries. The power-down countdown is run three ways: to completion, interrupted by command activity and a motor-on request, and with the enable low. Idle is dropped in the middle of a pass to confirm that the busy window is not shortened.

// File: rtl/fdc_sched_pkg.sv
package fdc_sched_pkg;

  typedef enum logic {
    LOOP_WAIT = 1'b0,
    LOOP_RUN  = 1'b1
  } loop_st_e;

  typedef struct packed {
    logic vld;
    logic hit;
  } sense_flags_t;

endpackage

// File: rtl/fdc_poll_seq.sv
module fdc_poll_seq
  import fdc_sched_pkg::*;
#(
  parameter int NUM_DRV    = 4,
  parameter int POLL_TICKS = 1000,
  parameter int SLOT_CYC   = 4,
  localparam int DRV_W = $clog2(NUM_DRV),
  localparam int IVL_W = $clog2(POLL_TICKS + 1),
  localparam int CYC_W = $clog2(SLOT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             tick,
  input  logic             idle,
  output logic             busy,
  output logic             scan,
  output logic [DRV_W-1:0] scan_drv
);

  loop_st_e         st_q, st_d;
  logic [IVL_W-1:0] ivl_q, ivl_d;
  logic [DRV_W-1:0] slot_q, slot_d;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  logic             ivl_done, slot_end, last_slot, start;

  assign busy      = (st_q == LOOP_RUN);
  assign ivl_done  = (ivl_q == IVL_W'(POLL_TICKS - 1));
  assign start     = idle && !busy && tick && ivl_done && !soft_rst;
  assign slot_end  = (cyc_q == CYC_W'(SLOT_CYC - 1));
  assign last_slot = (slot_q == DRV_W'(NUM_DRV - 1));
  assign scan      = busy && (cyc_q == '0);
  assign scan_drv  = slot_q;

  always_comb begin
    ivl_d  = ivl_q;
    st_d   = st_q;
    slot_d = slot_q;
    cyc_d  = cyc_q;
    if (soft_rst) begin
      ivl_d  = '0;
      st_d   = LOOP_WAIT;
      slot_d = '0;
      cyc_d  = '0;
    end else begin
      if (!idle || busy) begin
        ivl_d = '0;
      end else if (tick) begin
        ivl_d = ivl_done ? '0 : ivl_q + 1'b1;
      end
      if (busy) begin
        if (slot_end) begin
          cyc_d = '0;
          if (last_slot) begin
            st_d   = LOOP_WAIT;
            slot_d = '0;
          end else begin
            slot_d = slot_q + 1'b1;
          end
        end else begin
          cyc_d = cyc_q + 1'b1;
        end
      end else if (start) begin
        st_d   = LOOP_RUN;
        slot_d = '0;
        cyc_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LOOP_WAIT;
      ivl_q  <= '0;
      slot_q <= '0;
      cyc_q  <= '0;
    end else begin
      st_q   <= st_d;
      ivl_q  <= ivl_d;
      slot_q <= slot_d;
      cyc_q  <= cyc_d;
    end
  end

  AST_BUSY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(idle)); // R2

  AST_PASS_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !soft_rst && !(slot_end && last_slot)) |=> busy); // R9

endmodule

// File: rtl/fdc_ready_track.sv
module fdc_ready_track
  import fdc_sched_pkg::*;
#(
  parameter int NUM_DRV = 4,
  localparam int DRV_W = $clog2(NUM_DRV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             scan,
  input  logic [DRV_W-1:0] scan_drv,
  input  logic             poll_dis,
  input  logic             sense_req,
  output logic             irq,
  output logic             sense_vld,
  output logic             sense_hit,
  output logic [DRV_W-1:0] sense_drv
);

  logic [NUM_DRV-1:0] tog_q, tog_d;
  logic [NUM_DRV-1:0] rc_q, rc_d;
  logic [NUM_DRV-1:0] clr_m, set_m, visit_m;
  logic               found;
  logic [DRV_W-1:0]   low_idx;
  sense_flags_t       rsp_q, rsp_d;
  logic [DRV_W-1:0]   sdrv_q, sdrv_d;

  always_comb begin
    clr_m   = '0;
    found   = 1'b0;
    low_idx = '0;
    for (int i = 0; i < NUM_DRV; i++) begin
      if (rc_q[i] && !found) begin
        found   = 1'b1;
        low_idx = DRV_W'(i);
        clr_m   = NUM_DRV'(1) << i;
      end
    end
  end

  always_comb begin
    visit_m = scan ? (NUM_DRV'(1) << scan_drv) : '0;
    set_m   = poll_dis ? '0 : (visit_m & tog_q);
  end

  always_comb begin
    tog_d  = tog_q;
    rc_d   = rc_q;
    rsp_d  = '0;
    sdrv_d = sdrv_q;
    if (soft_rst) begin
      tog_d  = '1;
      rc_d   = '0;
      sdrv_d = '0;
    end else begin
      tog_d = tog_q & ~visit_m;
      rc_d  = (rc_q & ~(sense_req ? clr_m : '0)) | set_m;
      if (sense_req) begin
        rsp_d.vld = 1'b1;
        rsp_d.hit = found;
        sdrv_d    = low_idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q  <= '1;
      rc_q   <= '0;
      rsp_q  <= '0;
      sdrv_q <= '0;
    end else begin
      tog_q  <= tog_d;
      rc_q   <= rc_d;
      rsp_q  <= rsp_d;
      sdrv_q <= sdrv_d;
    end
  end

  assign irq       = |rc_q;
  assign sense_vld = rsp_q.vld;
  assign sense_hit = rsp_q.hit;
  assign sense_drv = sdrv_q;

  AST_SENSE_DRAINS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_req && (rc_q != '0) && !scan && !soft_rst)
      |=> ($countones(rc_q) + 1 == $countones($past(rc_q)))); // R5

  AST_POLL_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (scan && poll_dis && !soft_rst) |=> ((rc_q & ~$past(rc_q)) == '0)); // R4

endmodule

// File: rtl/fdc_step_queue.sv
module fdc_step_queue #(
  parameter int NUM_DRV = 4,
  localparam int DRV_W = $clog2(NUM_DRV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             scan,
  input  logic [DRV_W-1:0] scan_drv,
  input  logic             step_req,
  input  logic [DRV_W-1:0] step_req_drv,
  input  logic             step_req_dir,
  output logic             step_o,
  output logic             step_dir,
  output logic [DRV_W-1:0] step_drv
);

  logic [NUM_DRV-1:0] pend_q, pend_d;
  logic [NUM_DRV-1:0] dir_q, dir_d;
  logic [NUM_DRV-1:0] iss_m, req_m;
  logic               issue;
  logic               stp_q, stp_d, sdir_q, sdir_d;
  logic [DRV_W-1:0]   sdrv_q, sdrv_d;

  assign issue = scan && pend_q[scan_drv];
  assign iss_m = issue ? (NUM_DRV'(1) << scan_drv) : '0;
  assign req_m = step_req ? (NUM_DRV'(1) << step_req_drv) : '0;

  always_comb begin
    pend_d = pend_q;
    dir_d  = dir_q;
    stp_d  = 1'b0;
    sdir_d = sdir_q;
    sdrv_d = sdrv_q;
    if (soft_rst) begin
      pend_d = '0;
      dir_d  = '0;
      sdir_d = 1'b0;
      sdrv_d = '0;
    end else begin
      pend_d = (pend_q & ~iss_m) | req_m;
      for (int i = 0; i < NUM_DRV; i++) begin
        if (req_m[i]) dir_d[i] = step_req_dir;
      end
      if (issue) begin
        stp_d  = 1'b1;
        sdir_d = dir_q[scan_drv];
        sdrv_d = scan_drv;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      dir_q  <= '0;
      stp_q  <= 1'b0;
      sdir_q <= 1'b0;
      sdrv_q <= '0;
    end else begin
      pend_q <= pend_d;
      dir_q  <= dir_d;
      stp_q  <= stp_d;
      sdir_q <= sdir_d;
      sdrv_q <= sdrv_d;
    end
  end

  assign step_o   = stp_q;
  assign step_dir = sdir_q;
  assign step_drv = sdrv_q;

  AST_STEP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> !step_o); // R6

endmodule

// File: rtl/fdc_pd_timer.sv
module fdc_pd_timer #(
  parameter int PD_TICKS = 512000,
  localparam int PD_W = $clog2(PD_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic tick,
  input  logic motor_off_exp,
  input  logic auto_pd_en,
  input  logic cmd_act,
  input  logic motor_on,
  input  logic loop_head,
  output logic pwr_down
);

  logic [PD_W-1:0] cnt_q, cnt_d;
  logic            due_q, due_d;
  logic            pd_q, pd_d;
  logic            hold;

  assign hold = soft_rst || cmd_act || motor_on || !motor_off_exp || !auto_pd_en;

  always_comb begin
    cnt_d = cnt_q;
    due_d = due_q;
    pd_d  = pd_q;
    if (hold) begin
      cnt_d = '0;
      due_d = 1'b0;
      pd_d  = 1'b0;
    end else begin
      if (due_q && loop_head) pd_d = 1'b1;
      if (tick && !due_q) begin
        if (cnt_q == PD_W'(PD_TICKS - 1)) begin
          cnt_d = '0;
          due_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      due_q <= 1'b0;
      pd_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      due_q <= due_d;
      pd_q  <= pd_d;
    end
  end

  assign pwr_down = pd_q;

  AST_PD_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_act || motor_on) |=> !pwr_down); // R8

  AST_PD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down) |-> $past(auto_pd_en)); // R7

endmodule

// File: rtl/fdc_idle_sched.sv
module fdc_idle_sched #(
  parameter int NUM_DRV    = 4,
  parameter int POLL_TICKS = 1000,
  parameter int SLOT_CYC   = 4,
  parameter int PD_TICKS   = 512000,
  localparam int DRV_W = $clog2(NUM_DRV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             tick,
  input  logic             idle,
  input  logic             poll_dis,
  input  logic             sense_req,
  input  logic             step_req,
  input  logic [DRV_W-1:0] step_req_drv,
  input  logic             step_req_dir,
  input  logic             cmd_act,
  input  logic             motor_on,
  input  logic             motor_off_exp,
  input  logic             auto_pd_en,
  output logic             irq,
  output logic             poll_busy,
  output logic             sense_vld,
  output logic             sense_hit,
  output logic [DRV_W-1:0] sense_drv,
  output logic             step_o,
  output logic             step_dir,
  output logic [DRV_W-1:0] step_drv,
  output logic             pwr_down
);

  logic [1:0]       rs_q;
  logic             rst_i;
  logic             scan;
  logic [DRV_W-1:0] scan_drv;
  logic             loop_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  assign loop_head = scan && (scan_drv == '0);

  fdc_poll_seq #(
    .NUM_DRV(NUM_DRV), .POLL_TICKS(POLL_TICKS), .SLOT_CYC(SLOT_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_i), .soft_rst(soft_rst), .tick(tick), .idle(idle),
    .busy(poll_busy), .scan(scan), .scan_drv(scan_drv)
  );

  fdc_ready_track #(.NUM_DRV(NUM_DRV)) u_rdy (
    .clk(clk), .rst_n(rst_i), .soft_rst(soft_rst), .scan(scan),
    .scan_drv(scan_drv), .poll_dis(poll_dis), .sense_req(sense_req),
    .irq(irq), .sense_vld(sense_vld), .sense_hit(sense_hit),
    .sense_drv(sense_drv)
  );

  fdc_step_queue #(.NUM_DRV(NUM_DRV)) u_step (
    .clk(clk), .rst_n(rst_i), .soft_rst(soft_rst), .scan(scan),
    .scan_drv(scan_drv), .step_req(step_req), .step_req_drv(step_req_drv),
    .step_req_dir(step_req_dir), .step_o(step_o), .step_dir(step_dir),
    .step_drv(step_drv)
  );

  fdc_pd_timer #(.PD_TICKS(PD_TICKS)) u_pd (
    .clk(clk), .rst_n(rst_i), .soft_rst(soft_rst), .tick(tick),
    .motor_off_exp(motor_off_exp), .auto_pd_en(auto_pd_en),
    .cmd_act(cmd_act), .motor_on(motor_on), .loop_head(loop_head),
    .pwr_down(pwr_down)
  );

  AST_STEP_IN_PASS: assert property (@(posedge clk) disable iff (!rst_i)
    step_o |-> $past(poll_busy)); // R6

  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_i)
    soft_rst |=> (!poll_busy && !irq && !pwr_down && !step_o)); // R10

endmodule

// File: tb/fdc_idle_sched_tb_top.sv
module fdc_idle_sched_tb_top;

  localparam int ND  = 4;
  localparam int PT  = 8;
  localparam int SC  = 4;
  localparam int PDT = 40;

  logic       clk, rst_n;
  logic       soft_rst, tick, idle, poll_dis, sense_req, step_req;
  logic [1:0] step_req_drv;
  logic       step_req_dir, cmd_act, motor_on, motor_off_exp, auto_pd_en;
  logic       irq, poll_busy, sense_vld, sense_hit, step_o, step_dir, pwr_down;
  logic [1:0] sense_drv, step_drv;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;
  bit tick_en = 0;

  fdc_idle_sched #(.NUM_DRV(ND), .POLL_TICKS(PT), .SLOT_CYC(SC), .PD_TICKS(PDT)) dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .tick(tick), .idle(idle),
    .poll_dis(poll_dis), .sense_req(sense_req), .step_req(step_req),
    .step_req_drv(step_req_drv), .step_req_dir(step_req_dir),
    .cmd_act(cmd_act), .motor_on(motor_on), .motor_off_exp(motor_off_exp),
    .auto_pd_en(auto_pd_en), .irq(irq), .poll_busy(poll_busy),
    .sense_vld(sense_vld), .sense_hit(sense_hit), .sense_drv(sense_drv),
    .step_o(step_o), .step_dir(step_dir), .step_drv(step_drv),
    .pwr_down(pwr_down)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // Reference model state
  int  m_ivl, m_slot, m_cyc, m_pdc;
  bit  m_busy, m_due, m_pd;
  bit  m_tog[ND], m_rc[ND], m_pend[ND], m_dir[ND];
  bit  m_svld, m_shit, m_step, m_sdir;
  int  m_sdrv, m_stdrv;

  task automatic m_init();
    m_ivl = 0; m_slot = 0; m_cyc = 0; m_pdc = 0;
    m_busy = 0; m_due = 0; m_pd = 0;
    for (int i = 0; i < ND; i++) begin
      m_tog[i] = 1; m_rc[i] = 0; m_pend[i] = 0; m_dir[i] = 0;
    end
    m_svld = 0; m_shit = 0; m_step = 0; m_sdir = 0; m_sdrv = 0; m_stdrv = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst) begin
      m_init();
    end else begin
      bit start, scan, first;
      int sd;
      start = idle && !m_busy && tick && (m_ivl == PT - 1);
      scan  = m_busy && (m_cyc == 0);
      sd    = m_slot;
      // sense: lowest flagged drive first
      m_svld = sense_req;
      if (sense_req) begin
        m_shit = 0; m_sdrv = 0; first = 1;
        for (int i = 0; i < ND; i++)
          if (m_rc[i] && first) begin
            m_rc[i] = 0; m_shit = 1; m_sdrv = i; first = 0;
          end
      end else m_shit = 0;
      m_step = 0;
      if (scan) begin
        if (m_tog[sd]) begin
          m_tog[sd] = 0;
          if (!poll_dis) m_rc[sd] = 1;
        end
        if (m_pend[sd]) begin
          m_step = 1; m_sdir = m_dir[sd]; m_stdrv = sd; m_pend[sd] = 0;
        end
      end
      if (step_req) begin
        m_pend[step_req_drv] = 1; m_dir[step_req_drv] = step_req_dir;
      end
      if (cmd_act || motor_on || !motor_off_exp || !auto_pd_en) begin
        m_pdc = 0; m_due = 0; m_pd = 0;
      end else begin
        if (m_due && scan && sd == 0) m_pd = 1;
        if (tick && !m_due) begin
          if (m_pdc == PDT - 1) begin m_due = 1; m_pdc = 0; end
          else m_pdc++;
        end
      end
      if (!idle || m_busy) m_ivl = 0;
      else if (tick) m_ivl = (m_ivl == PT - 1) ? 0 : m_ivl + 1;
      if (m_busy) begin
        if (m_cyc == SC - 1) begin
          m_cyc = 0;
          if (m_slot == ND - 1) begin m_busy = 0; m_slot = 0; end
          else m_slot++;
        end else m_cyc++;
      end else if (start) begin
        m_busy = 1; m_slot = 0; m_cyc = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int m_irq();
    int r = 0;
    for (int i = 0; i < ND; i++) r |= m_rc[i];
    return r;
  endfunction

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      chk(irq == m_irq(), "R3 irq", irq, m_irq());
      chk(poll_busy == m_busy, "R2 busy", poll_busy, m_busy);
      chk(sense_vld == m_svld, "R5 sense_vld", sense_vld, m_svld);
      if (m_svld) begin
        chk(sense_hit == m_shit, "R5 sense_hit", sense_hit, m_shit);
        chk(sense_drv == m_sdrv, "R5 sense_drv", sense_drv, m_sdrv);
      end
      chk(step_o == m_step, "R6 step_o", step_o, m_step);
      if (m_step) begin
        chk(step_dir == m_sdir, "R6 step_dir", step_dir, m_sdir);
        chk(step_drv == m_stdrv, "R6 step_drv", step_drv, m_stdrv);
      end
      chk(pwr_down == m_pd, "R7 pwr_down", pwr_down, m_pd);
    end
    if (tick_en) tick <= ~tick;
    else tick <= 0;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 100000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      finish_run();
    end
  end

  task automatic pulse_sense(input int exp_drv, input bit exp_hit, input string tag);
    sense_req = 1;
    @(negedge clk);
    sense_req = 0;
    chk(sense_vld && sense_hit == exp_hit && sense_drv == exp_drv, tag,
        {sense_hit, sense_drv}, {exp_hit, 2'(exp_drv)});
  endtask

  task automatic pulse_soft();
    soft_rst = 1;
    @(negedge clk);
    soft_rst = 0;
  endtask

  initial begin
    int blen;
    rst_n = 0; soft_rst = 0; tick = 0; idle = 0; poll_dis = 0; sense_req = 0;
    step_req = 0; step_req_drv = 0; step_req_dir = 0; cmd_act = 0;
    motor_on = 0; motor_off_exp = 0; auto_pd_en = 0;
    wait_n(3);
    chk(!irq && !poll_busy && !sense_vld && !step_o && !pwr_down, "R1 reset outputs",
        {irq, poll_busy, sense_vld, step_o, pwr_down}, 0);
    rst_n = 1;
    wait_n(4);
    chk(!irq && !poll_busy && !pwr_down, "R1 after release", {irq, poll_busy, pwr_down}, 0);

    // first pass after reset: all flags latched
    tick_en = 1; idle = 1;
    while (!poll_busy) @(negedge clk);
    blen = 0;
    while (poll_busy) begin blen++; @(negedge clk); end
    chk(blen == ND * SC, "R2 pass length", blen, ND * SC);
    chk(irq == 1, "R3 irq after first pass", irq, 1);
    wait_n(40);
    pulse_sense(0, 1, "R5 sense drive 0");
    pulse_sense(1, 1, "R5 sense drive 1");
    pulse_sense(2, 1, "R5 sense drive 2");
    chk(irq == 1, "R5 irq with one flag left", irq, 1);
    pulse_sense(3, 1, "R5 sense drive 3");
    chk(irq == 0, "R5 irq cleared", irq, 0);
    pulse_sense(0, 0, "R5 empty sense");
    wait_n(60);
    chk(irq == 0, "R3 no further flags", irq, 0);

    // polling disabled across a software reset
    poll_dis = 1;
    pulse_soft();
    chk(!poll_busy && !irq, "R10 soft reset state", {poll_busy, irq}, 0);
    wait_n(60);
    chk(irq == 0, "R4 polling off suppresses", irq, 0);
    poll_dis = 0;
    wait_n(60);
    chk(irq == 0, "R4 discarded event stays gone", irq, 0);

    // software reset re-arms the toggle
    pulse_soft();
    wait_n(60);
    chk(irq == 1, "R10 rearmed after soft reset", irq, 1);
    repeat (4) begin sense_req = 1; @(negedge clk); sense_req = 0; @(negedge clk); end
    chk(irq == 0, "R5 drained", irq, 0);

    // steps with polling off
    poll_dis = 1;
    step_req = 1; step_req_drv = 2; step_req_dir = 1; @(negedge clk);
    step_req_drv = 0; step_req_dir = 0; @(negedge clk);
    step_req = 0;
    blen = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (step_o) blen++;
    end
    chk(blen == 2, "R6 two step pulses", blen, 2);

    // idle drops mid-pass: pass continues
    while (!poll_busy) @(negedge clk);
    wait_n(3);
    idle = 0; cmd_act = 1; @(negedge clk); cmd_act = 0;
    blen = 0;
    while (poll_busy) begin blen++; @(negedge clk); end
    chk(blen == ND * SC - 4, "R9 pass not cut", blen, ND * SC - 4);
    wait_n(40);
    chk(poll_busy == 0, "R2 no pass while not idle", poll_busy, 0);
    idle = 1;

    // power-down countdown
    motor_off_exp = 1; auto_pd_en = 1;
    wait_n(200);
    chk(pwr_down == 1, "R7 power-down reached", pwr_down, 1);
    cmd_act = 1; @(negedge clk); cmd_act = 0;
    chk(pwr_down == 0, "R8 command clears power-down", pwr_down, 0);
    wait_n(200);
    chk(pwr_down == 1, "R7 power-down again", pwr_down, 1);
    motor_on = 1; @(negedge clk); motor_on = 0;
    chk(pwr_down == 0, "R8 motor-on clears power-down", pwr_down, 0);
    auto_pd_en = 0;
    wait_n(250);
    chk(pwr_down == 0, "R7 disabled never powers down", pwr_down, 0);

    wait_n(5);
    finish_run();
  end

endmodule